// File: doc/BRIEF.md
# Wrapper Instruction Register Controller

This block holds and decodes the instruction that sets the operating mode of a test wrapper placed around an embedded core. Six direct control lines drive it, with no state machine in between. One pattern on those lines opens the instruction register for receiving. While that pattern holds and the shift line is high, each clock moves one instruction bit in from the serial input. A second pattern copies the shifted word into an update stage. Only the update stage sets the mode. Shifting therefore never disturbs the wrapper mode that is already active.

The update stage is decoded into a one-hot vector of six wrapper modes, which goes to the wrapper datapath. The serial output is steered by the control lines. While the register is receiving, the output carries the last bit of the instruction shift stage. At all other times it passes the datapath's serial output through, so the same pair of serial pins also serves as the serial test access path of the selected mode.

Top module: `wir_ctrl_top`

## Requirements
- R1: While reset is asserted (`rst_n` low), and after it is released, the update stage holds the Normal instruction, so `mode_sel` equals 6'b000001.
- R2: `wctl[i]` is control line i. Receive is `wctl[4:0]`=5'b00001 (line 0 high, lines 1 to 4 low). Shift is receive with `wctl[5]`=1. Update is `wctl`=6'b100010 (lines 1 and 5 high, the rest low). Every other value is a no-op for both register stages.
- R3: `mode_sel` changes only on the clock edge that follows an update cycle. It is stable during shifting, holding and every other control value.
- R4: An update loads the last six bits that were shifted in. The first bit shifted ends up in the most significant position, so an instruction written MSB first is shifted in left to right.
- R5: The instruction codes and their `mode_sel` bits are: Normal 000000 gives bit 0; Serial Internal 111000 gives bit 1; Serial External 000011 gives bit 2; Serial Bypass 000100 gives bit 3; Parallel Internal 000001 gives bit 4; Parallel External 000010 gives bit 5.
- R6: Any code not listed in R5 selects Serial Bypass (bit 3). `mode_sel` always has exactly one bit set.
- R7: During receive, `ser_out` equals the MSB of the shift stage. Shifting a new word therefore brings out the previous shift content, MSB first.
- R8: When the control lines are not in receive, `ser_out` equals `dp_ser_out`.
- R9: In receive with `wctl[5]`=0, the shift stage keeps its content across clock edges, so `ser_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wctl | input | 6 | Direct control lines; bit i is control line i |
| ser_in | input | 1 | Serial input, feeding the instruction shift stage |
| dp_ser_out | input | 1 | Serial output of the wrapper datapath |
| ser_out | output | 1 | Serial output, steered between instruction path and datapath |
| mode_sel | output | 6 | One-hot wrapper mode from the active instruction |

## Verification
The bench builds the block with its defaults: a 6-bit instruction and six modes. At that size all 64 instruction codes can be shifted, held and updated in turn. Each load also shifts out the previous word, so the serial echo is checked for every code, and every unused code is seen to fall back to bypass. All 64 control-line values are also swept, one cycle each, against a shifted word that differs from the active one, so a stray update or a wrong output steering would be visible at the ports.

// File: rtl/wir_pkg.sv
package wir_pkg;

   localparam int unsigned NUM_MODES = 6;

   // Bit positions of the one-hot wrapper mode vector
   typedef enum int unsigned {
      M_NORMAL  = 0,
      M_SER_INT = 1,
      M_SER_EXT = 2,
      M_BYPASS  = 3,
      M_PAR_INT = 4,
      M_PAR_EXT = 5
   } mode_idx_e;

   // Decoded meaning of the control lines
   typedef struct packed {
      logic recv;
      logic shift;
      logic update;
   } ctl_dec_t;

endpackage

// File: rtl/wir_ctl_decode.sv
module wir_ctl_decode
   import wir_pkg::*;
#(
   parameter int unsigned CTL_W     = 6,
   parameter int unsigned SHIFT_BIT = 5,
   parameter logic [CTL_W-2:0] RECV_PAT = 5'b00001,
   parameter logic [CTL_W-1:0] UPD_PAT  = 6'b100010
) (
   input  logic [CTL_W-1:0] wctl,
   output ctl_dec_t         dec
);

   localparam int unsigned LOW_W = CTL_W - 1;

   if (CTL_W != 6) begin : g_bad_width
      $error("wir_ctl_decode: CTL_W must be 6");
   end
   if (SHIFT_BIT != CTL_W - 1) begin : g_bad_shift
      $error("wir_ctl_decode: shift line must be the top control line");
   end

   logic recv_match;

   assign recv_match = (wctl[LOW_W-1:0] == RECV_PAT);

   always_comb begin
      dec.recv   = recv_match;
      dec.shift  = recv_match & wctl[SHIFT_BIT];
      dec.update = (wctl == UPD_PAT);
   end

endmodule

// File: rtl/wir_shift_update.sv
module wir_shift_update #(
   parameter int unsigned IR_LEN = 6,
   parameter logic [IR_LEN-1:0] RESET_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              update_en,
   input  logic              ser_in,
   output logic [IR_LEN-1:0] shift_q,
   output logic [IR_LEN-1:0] upd_q
);

   if (IR_LEN < 2) begin : g_bad_len
      $error("wir_shift_update: IR_LEN must be at least 2");
   end

   // Shift stage: new bits enter at the LSB, so the first bit ends at the MSB
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
      end else if (shift_en) begin
         shift_q <= {shift_q[IR_LEN-2:0], ser_in};
      end
   end

   // Update stage: only this one drives the wrapper mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_q <= RESET_CODE;
      end else if (update_en) begin
         upd_q <= shift_q;
      end
   end

endmodule

// File: rtl/wir_mode_decode.sv
module wir_mode_decode
   import wir_pkg::*;
#(
   parameter int unsigned IR_LEN = 6,
   parameter logic [IR_LEN-1:0] CODE_NORMAL  = 6'b000000,
   parameter logic [IR_LEN-1:0] CODE_SER_INT = 6'b111000,
   parameter logic [IR_LEN-1:0] CODE_SER_EXT = 6'b000011,
   parameter logic [IR_LEN-1:0] CODE_BYPASS  = 6'b000100,
   parameter logic [IR_LEN-1:0] CODE_PAR_INT = 6'b000001,
   parameter logic [IR_LEN-1:0] CODE_PAR_EXT = 6'b000010
) (
   input  logic [IR_LEN-1:0]    instr,
   output logic [NUM_MODES-1:0] mode
);

   // Entry i is the code of mode bit i
   localparam logic [NUM_MODES-1:0][IR_LEN-1:0] CODES = {
      CODE_PAR_EXT, CODE_PAR_INT, CODE_BYPASS,
      CODE_SER_EXT, CODE_SER_INT, CODE_NORMAL
   };
   localparam logic [NUM_MODES-1:0] FALLBACK = NUM_MODES'(1) << M_BYPASS;

   for (genvar i = 0; i < NUM_MODES; i++) begin : g_uniq_i
      for (genvar j = i + 1; j < NUM_MODES; j++) begin : g_uniq_j
         if (CODES[i] == CODES[j]) begin : g_dup
            $error("wir_mode_decode: two modes share one code");
         end
      end
   end

   logic [NUM_MODES-1:0] hit;

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_hit
      assign hit[m] = (instr == CODES[m]);
   end

   assign mode = (|hit) ? hit : FALLBACK;

endmodule

// File: rtl/wir_ctrl_top.sv
module wir_ctrl_top
   import wir_pkg::*;
#(
   parameter int unsigned IR_LEN     = 6,
   parameter int unsigned CTL_W      = 6,
   parameter bit          ONEHOT_REG = 1'b0,
   parameter logic [IR_LEN-1:0] CODE_NORMAL  = 6'b000000,
   parameter logic [IR_LEN-1:0] CODE_SER_INT = 6'b111000,
   parameter logic [IR_LEN-1:0] CODE_SER_EXT = 6'b000011,
   parameter logic [IR_LEN-1:0] CODE_BYPASS  = 6'b000100,
   parameter logic [IR_LEN-1:0] CODE_PAR_INT = 6'b000001,
   parameter logic [IR_LEN-1:0] CODE_PAR_EXT = 6'b000010
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CTL_W-1:0]     wctl,
   input  logic                 ser_in,
   input  logic                 dp_ser_out,
   output logic                 ser_out,
   output logic [NUM_MODES-1:0] mode_sel
);

   localparam logic [NUM_MODES-1:0] RESET_MODE = NUM_MODES'(1) << M_NORMAL;

   if (IR_LEN < 3) begin : g_bad_len
      $error("wir_ctrl_top: IR_LEN must be at least 3");
   end

   ctl_dec_t          dec;
   logic [IR_LEN-1:0] shift_q;
   logic [IR_LEN-1:0] upd_q;
   logic [IR_LEN-1:0] dec_in;
   logic [NUM_MODES-1:0] dec_mode;

   wir_ctl_decode #(
      .CTL_W(CTL_W)
   ) u_ctl (
      .wctl (wctl),
      .dec  (dec)
   );

   wir_shift_update #(
      .IR_LEN     (IR_LEN),
      .RESET_CODE (CODE_NORMAL)
   ) u_ir (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (dec.shift),
      .update_en (dec.update),
      .ser_in    (ser_in),
      .shift_q   (shift_q),
      .upd_q     (upd_q)
   );

   wir_mode_decode #(
      .IR_LEN       (IR_LEN),
      .CODE_NORMAL  (CODE_NORMAL),
      .CODE_SER_INT (CODE_SER_INT),
      .CODE_SER_EXT (CODE_SER_EXT),
      .CODE_BYPASS  (CODE_BYPASS),
      .CODE_PAR_INT (CODE_PAR_INT),
      .CODE_PAR_EXT (CODE_PAR_EXT)
   ) u_mode (
      .instr (dec_in),
      .mode  (dec_mode)
   );

   if (ONEHOT_REG) begin : g_mode_reg
      // Decode the shift stage and store the mode as one-hot flops
      logic [NUM_MODES-1:0] mode_q;
      assign dec_in = shift_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q <= RESET_MODE;
         end else if (dec.update) begin
            mode_q <= dec_mode;
         end
      end
      assign mode_sel = mode_q;
   end else begin : g_mode_comb
      // Decode the update stage directly
      assign dec_in   = upd_q;
      assign mode_sel = dec_mode;
   end

   // Serial output steering
   assign ser_out = dec.recv ? shift_q[IR_LEN-1] : dp_ser_out;

endmodule

// File: rtl/wir_ctl_check.sv
module wir_ctl_check #(
   parameter int unsigned NMODE = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [5:0]       wctl,
   input logic             ser_out,
   input logic             dp_ser_out,
   input logic [NMODE-1:0] mode_sel
);

   localparam logic [5:0] UPD  = 6'b100010;
   localparam logic [5:0] HOLD = 6'b000001;

   AST_RESET_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> mode_sel == NMODE'(1)); // R1

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wctl != UPD) |=> $stable(mode_sel)); // R3

   AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_sel) == 1); // R6

   AST_SO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wctl[4:0] != 5'b00001) |-> ser_out == dp_ser_out); // R8

   AST_SO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wctl == HOLD) |=> ((wctl[4:0] != 5'b00001) || $stable(ser_out))); // R9

endmodule

bind wir_ctrl_top wir_ctl_check #(.NMODE(6)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wctl       (wctl),
   .ser_out    (ser_out),
   .dp_ser_out (dp_ser_out),
   .mode_sel   (mode_sel)
);

// File: tb/wir_ctrl_top_test.sv
module wir_ctrl_top_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] wctl = '0;
   logic       ser_in = 1'b0;
   logic       dp_ser_out = 1'b0;
   logic       ser_out;
   logic [5:0] mode_sel;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   localparam logic [5:0] C_SHIFT = 6'b100001;
   localparam logic [5:0] C_HOLD  = 6'b000001;
   localparam logic [5:0] C_UPD   = 6'b100010;

   always #2.5 clk = ~clk;

   wir_ctrl_top uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wctl       (wctl),
      .ser_in     (ser_in),
      .dp_ser_out (dp_ser_out),
      .ser_out    (ser_out),
      .mode_sel   (mode_sel)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // Expected one-hot mode for an instruction code
   function automatic logic [5:0] exp_mode(input logic [5:0] c);
      int b;
      case (c)
         6'b000000: b = 0;
         6'b111000: b = 1;
         6'b000011: b = 2;
         6'b000100: b = 3;
         6'b000001: b = 4;
         6'b000010: b = 5;
         default:   b = 3;
      endcase
      return 6'(1 << b);
   endfunction

   task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   // Shift a word MSB first; checks the echo of the old word and a stable mode
   task automatic shift_word(input logic [5:0] w, input logic [5:0] old_sr,
                             input logic [5:0] cur_mode);
      for (int k = 5; k >= 0; k--) begin
         @(negedge clk);
         wctl = C_SHIFT;
         ser_in = w[k];
         dp_ser_out = ~old_sr[k];
         #1;
         check("R7 serial echo", {5'b0, ser_out}, {5'b0, old_sr[k]});
         check("R3 mode during shift", mode_sel, cur_mode);
      end
   endtask

   task automatic update_now;
      @(negedge clk);
      wctl = C_UPD;
      @(negedge clk);
      wctl = '0;
      #1;
   endtask

   initial begin
      logic [5:0] sr;
      logic [5:0] cur;
      // reset
      #1;
      check("R1 mode in reset", mode_sel, 6'b000001);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1 mode after reset", mode_sel, 6'b000001);
      dp_ser_out = 1'b1;
      #1;
      check("R8 so follows datapath 1", {5'b0, ser_out}, 6'd1);
      dp_ser_out = 1'b0;
      #1;
      check("R8 so follows datapath 0", {5'b0, ser_out}, 6'd0);

      sr = '0;
      cur = 6'b000001;
      // all codes
      for (int c = 0; c < 64; c++) begin
         shift_word(6'(c), sr, cur);
         sr = 6'(c);
         @(negedge clk);
         wctl = C_HOLD;
         ser_in = ~sr[5];
         dp_ser_out = ~sr[5];
         #1;
         check("R9 hold before edge", {5'b0, ser_out}, {5'b0, sr[5]});
         @(negedge clk);
         #1;
         check("R9 hold after edge", {5'b0, ser_out}, {5'b0, sr[5]});
         check("R3 mode during hold", mode_sel, cur);
         update_now();
         cur = exp_mode(6'(c));
         check("R4 R5 R6 mode after update", mode_sel, cur);
      end

      // Active SerExt, shift stage SerInt, then sweep all control values
      shift_word(6'b000011, sr, cur);
      update_now();
      cur = 6'b000100;
      check("R5 serial external", mode_sel, cur);
      shift_word(6'b111000, 6'b000011, cur);
      sr = 6'b111000;
      for (int v = 0; v < 64; v++) begin
         logic [5:0] cv;
         logic recv;
         cv = 6'(v);
         recv = (cv[4:0] == 5'b00001);
         if (cv == C_UPD || cv == C_SHIFT) continue;
         @(negedge clk);
         wctl = cv;
         dp_ser_out = 1'b0;
         ser_in = 1'b0;
         #1;
         check("R2 R8 so steering", {5'b0, ser_out}, recv ? {5'b0, sr[5]} : 6'd0);
         @(negedge clk);
         wctl = '0;
         #1;
         check("R2 R3 no update on other control", mode_sel, cur);
      end
      // shift stage must be intact: update now gives Serial Internal
      update_now();
      check("R2 R5 serial internal after sweep", mode_sel, 6'b000010);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule